// File: doc/BRIEF.md
# Transmit Width-Halving Byte Serializer

This block sits on the transmit side between the clock-crossing FIFO and the line encoder. The fabric side delivers a word twice as wide as the encoder accepts, at half the encoder's clock rate. The block splits each word into two halves and hands them to the encoder on two consecutive full-rate cycles, lower half first. Every byte lane has a control-identifier bit that moves with its byte. The fabric interface can therefore run at half frequency when the line rate is high.

The half-rate domain is modelled as an enable pulse (`halfEn`) on the full-rate clock. A parameter selects the channel width: single-width (16-bit input, 8-bit output) or double-width (32-bit input, 16-bit output). When the `serEn` input is low, the block stops splitting words. In that mode the lower half of the input passes to the output each full-rate cycle, through one register stage.

Top module: `tx_byte_serializer`

## Requirements
- R1: While reset is asserted, and after reset until the first word is captured, `outData` is zero and every `outCtrl` bit is low.
- R2: With `serEn` high, a word presented while `halfEn` is high is captured at that clock edge. On the next cycle `outData` shows its lower half, meaning input lanes 0..OUT_LANES-1.
- R3: On the cycle after the lower half, `outData` shows the upper half of the captured word. This holds even if the input has changed meanwhile.
- R4: Control bit `inCtrl[i]` belongs to input lane `i`, which is bits `8*i+7 : 8*i`. It appears on `outCtrl` in the same cycle and output lane position as its byte.
- R5: With `serEn` high, in a cycle where no word is captured and no upper half is pending, the output returns to zero with all control bits low.
- R6: With `serEn` low, `outData` and `outCtrl` equal the lower half of the input and the lower control bits from one cycle earlier. `halfEn` and the upper half of the input have no effect.
- R7: With `WIDE_MODE`=1, the input is 32 bits with 4 control bits and the output is 16 bits with 2 control bits. Lanes 0-1 are emitted first, then lanes 2-3.
- R8: If `halfEn` is high while an upper half is still pending, the new word wins. Its lower half is emitted, and the old upper half is dropped.
- R9: Dropping `serEn` while an upper half is pending discards that upper half. It does not appear later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate parallel clock |
| rstN | input | 1 | Active-low synchronous reset |
| serEn | input | 1 | 1: split words; 0: pass the lower half through |
| halfEn | input | 1 | Half-rate capture enable |
| inData | input | IN_W (16 or 32) | Double-width word from the FIFO |
| inCtrl | input | IN_LANES (2 or 4) | Control-identifier bit per input byte |
| outData | output | OUT_W (8 or 16) | Single-step word to the encoder |
| outCtrl | output | OUT_LANES (1 or 2) | Control-identifier bit per output byte |

## Verification
The bench changes the input after each capture. A design that reads the upper half straight from the input port, instead of from a holding register, then shows the wrong byte in the second cycle. Control patterns are made asymmetric, so a swapped lane order or a control bit tied to the wrong lane shows up as a mismatch. Two back-to-back captures and a mid-word drop of `serEn` target the stale-upper-half hazard: a design that keeps a pending flag alive would emit an old byte. Bypass is checked with `halfEn` toggling and the upper input half set to garbage, so that any leak of either into the output is seen.

// File: rtl/txser_pkg.sv
package txser_pkg;
  typedef struct packed {
    logic capture;   // latch new word, emit its lower half
    logic emitHigh;  // emit held upper half
    logic bypass;    // pass lower half of input straight on
    logic idle;      // nothing to send, drive zero
  } serStrobe_t;
endpackage

// File: rtl/txser_ctrl.sv
module txser_ctrl
  import txser_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       serEn,
  input  logic       halfEn,
  output serStrobe_t stb
);
  logic pendQ;

  always_comb begin
    stb          = '0;
    stb.bypass   = !serEn;
    stb.capture  = serEn && halfEn;
    stb.emitHigh = serEn && !halfEn && pendQ;
    stb.idle     = serEn && !halfEn && !pendQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= stb.capture;
  end

  // R3
  high_after_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.emitHigh |-> $past(stb.capture));
  // R9
  bypass_clears_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.bypass |=> !stb.emitHigh);
endmodule

// File: rtl/txser_datapath.sv
module txser_datapath
  import txser_pkg::*;
#(
  parameter int LANE_BITS = 8,
  parameter int OUT_LANES = 1,
  localparam int IN_LANES = 2 * OUT_LANES,
  localparam int OUT_W    = OUT_LANES * LANE_BITS,
  localparam int IN_W     = 2 * OUT_W
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  serStrobe_t           stb,
  input  logic [IN_W-1:0]      inData,
  input  logic [IN_LANES-1:0]  inCtrl,
  output logic [OUT_W-1:0]     outData,
  output logic [OUT_LANES-1:0] outCtrl
);
  logic [OUT_W-1:0]     holdDataQ;
  logic [OUT_LANES-1:0] holdCtrlQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdDataQ <= '0;
      holdCtrlQ <= '0;
    end else if (stb.capture) begin
      holdDataQ <= inData[IN_W-1:OUT_W];
      holdCtrlQ <= inCtrl[IN_LANES-1:OUT_LANES];
    end
  end

  for (genvar g = 0; g < OUT_LANES; g++) begin : g_lane
    logic [LANE_BITS-1:0] laneQ;
    logic                 laneCtrlQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneQ     <= '0;
        laneCtrlQ <= 1'b0;
      end else if (stb.capture || stb.bypass) begin
        laneQ     <= inData[g*LANE_BITS +: LANE_BITS];
        laneCtrlQ <= inCtrl[g];
      end else if (stb.emitHigh) begin
        laneQ     <= holdDataQ[g*LANE_BITS +: LANE_BITS];
        laneCtrlQ <= holdCtrlQ[g];
      end else begin
        laneQ     <= '0;
        laneCtrlQ <= 1'b0;
      end
    end
    assign outData[g*LANE_BITS +: LANE_BITS] = laneQ;
    assign outCtrl[g] = laneCtrlQ;
  end

  // R2
  low_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (outData == $past(inData[OUT_W-1:0])) && (outCtrl == $past(inCtrl[OUT_LANES-1:0])));
  // R3
  high_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.emitHigh |=> (outData == $past(holdDataQ)) && (outCtrl == $past(holdCtrlQ)));
  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.idle |=> (outData == '0) && (outCtrl == '0));
  // R6
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.bypass |=> (outData == $past(inData[OUT_W-1:0])) && (outCtrl == $past(inCtrl[OUT_LANES-1:0])));
endmodule

// File: rtl/tx_byte_serializer.sv
module tx_byte_serializer
  import txser_pkg::*;
#(
  parameter int LANE_BITS = 8,
  parameter bit WIDE_MODE = 1'b0,
  localparam int OUT_LANES = WIDE_MODE ? 2 : 1,
  localparam int IN_LANES  = 2 * OUT_LANES,
  localparam int OUT_W     = OUT_LANES * LANE_BITS,
  localparam int IN_W      = 2 * OUT_W
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serEn,
  input  logic                 halfEn,
  input  logic [IN_W-1:0]      inData,
  input  logic [IN_LANES-1:0]  inCtrl,
  output logic [OUT_W-1:0]     outData,
  output logic [OUT_LANES-1:0] outCtrl
);
  serStrobe_t stb;

  txser_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .serEn  (serEn),
    .halfEn (halfEn),
    .stb    (stb)
  );

  txser_datapath #(
    .LANE_BITS (LANE_BITS),
    .OUT_LANES (OUT_LANES)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inData  (inData),
    .inCtrl  (inCtrl),
    .outData (outData),
    .outCtrl (outCtrl)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (outData == '0) && (outCtrl == '0));
endmodule

// File: tb/tx_byte_serializer_tb_top.sv
module tx_byte_serializer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serEn = 1'b1;
  logic halfEn = 1'b0;
  logic [15:0] inData = '0;
  logic [1:0]  inCtrl = '0;
  logic [7:0]  outData;
  logic [0:0]  outCtrl;
  logic [31:0] wInData = '0;
  logic [3:0]  wInCtrl = '0;
  logic [15:0] wOutData;
  logic [1:0]  wOutCtrl;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  tx_byte_serializer dut_i (
    .clk(clk), .rstN(rstN), .serEn(serEn), .halfEn(halfEn),
    .inData(inData), .inCtrl(inCtrl), .outData(outData), .outCtrl(outCtrl)
  );

  tx_byte_serializer #(.WIDE_MODE(1'b1)) dutWide_i (
    .clk(clk), .rstN(rstN), .serEn(serEn), .halfEn(halfEn),
    .inData(wInData), .inCtrl(wInCtrl), .outData(wOutData), .outCtrl(wOutCtrl)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chkNarrow(input string req, input logic [7:0] d, input logic c);
    check(req, {23'd0, outCtrl, outData}, {23'd0, c, d});
  endtask

  task automatic chkWide(input string req, input logic [15:0] d, input logic [1:0] c);
    check(req, {14'd0, wOutCtrl, wOutData}, {14'd0, c, d});
  endtask

  task automatic testReset();
    rstN = 1'b0; serEn = 1'b1; halfEn = 1'b0;
    inData = 16'hBEEF; inCtrl = 2'b11; wInData = 32'hCAFEF00D; wInCtrl = 4'hF;
    step(); step();
    chkNarrow("R1 in reset", 8'h00, 1'b0);
    chkWide("R1 wide in reset", 16'h0000, 2'b00);
    rstN = 1'b1;
    step(); step();
    chkNarrow("R1 after reset no capture", 8'h00, 1'b0);
    chkWide("R1 wide after reset no capture", 16'h0000, 2'b00);
  endtask

  task automatic testSerial(input logic [15:0] w, input logic [1:0] c,
                            input logic [31:0] ww, input logic [3:0] wc);
    serEn = 1'b1; halfEn = 1'b1;
    inData = w; inCtrl = c; wInData = ww; wInCtrl = wc;
    step();
    chkNarrow("R2 R4 lower half", w[7:0], c[0]);
    chkWide("R7 wide lanes 0-1", ww[15:0], wc[1:0]);
    halfEn = 1'b0; inData = ~w; inCtrl = ~c; wInData = ~ww; wInCtrl = ~wc;
    step();
    chkNarrow("R3 R4 upper half", w[15:8], c[1]);
    chkWide("R7 wide lanes 2-3", ww[31:16], wc[3:2]);
    step();
    chkNarrow("R5 idle zero", 8'h00, 1'b0);
    chkWide("R5 wide idle zero", 16'h0000, 2'b00);
  endtask

  task automatic testBypass();
    serEn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      halfEn = i[0];
      inData = {8'hE0 + 8'(i), 8'h30 + 8'(i)};
      inCtrl = {1'b1, i[1]};
      wInData = {16'hFFFF, 16'h4400 + 16'(i)};
      wInCtrl = {2'b11, i[1], ~i[1]};
      step();
      chkNarrow("R6 bypass", 8'h30 + 8'(i), i[1]);
      chkWide("R6 wide bypass", 16'h4400 + 16'(i), {i[1], ~i[1]});
    end
  endtask

  task automatic testBackToBack();
    serEn = 1'b1; halfEn = 1'b1; inData = 16'h11AA; inCtrl = 2'b10;
    step();
    chkNarrow("R2 first of pair", 8'hAA, 1'b0);
    inData = 16'h22BB; inCtrl = 2'b01;
    step();
    chkNarrow("R8 new word wins", 8'hBB, 1'b1);
    halfEn = 1'b0; inData = 16'h0000; inCtrl = 2'b00;
    step();
    chkNarrow("R8 upper of new word", 8'h22, 1'b0);
  endtask

  task automatic testBypassDiscard();
    serEn = 1'b1; halfEn = 1'b1; inData = 16'h77C3; inCtrl = 2'b11;
    step();
    chkNarrow("R2 before discard", 8'hC3, 1'b1);
    serEn = 1'b0; halfEn = 1'b0; inData = 16'h5566; inCtrl = 2'b00;
    step();
    chkNarrow("R9 bypass replaces upper half", 8'h66, 1'b0);
    serEn = 1'b1;
    step();
    chkNarrow("R9 no stale upper half", 8'h00, 1'b0);
  endtask

  initial begin
    testReset();
    testSerial(16'hA55A, 2'b10, 32'hDDCCBBAA, 4'b1010);
    testSerial(16'h0FF0, 2'b01, 32'h12345678, 4'b0110);
    testSerial(16'h1234, 2'b11, 32'h80FF0001, 4'b1001);
    testBypass();
    testBackToBack();
    testBypassDiscard();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500us;
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule